// File: doc/BRIEF.md
# Least-Frequently-Used Frame Replacer

This block keeps the bookkeeping for a small, fixed pool of page frames and chooses which resident page gives up its frame when a reference misses. It takes at most one page-number reference per cycle. For each reference it reports, one cycle later, whether the page was already resident, which frame served or received it, and whether a resident page was pushed out and which one. Data movement, backing store traffic and address translation are handled elsewhere.

Each frame holds a page number, a saturating use count and an arrival stamp. While frames are still empty, a miss takes the lowest-numbered empty frame. Once all frames are occupied, a miss replaces the page with the smallest use count. Among pages that share that count, the one that arrived first is replaced. A newly loaded page always begins with a count of one. Arrival stamps come from a counter that advances once per load. Stamps are ordered by their distance from the current counter value, so the counter may wrap.

Top module: `lfu_frame_replacer`

## Requirements
- R1: After reset every frame is empty. Misses fill frames in index order 0, 1, 2, 3 and report no eviction until all four are occupied.
- R2: A reference to a resident page reports hit=1 and that page's frame, reports no eviction, and adds one to the page's use count.
- R3: Use counts are 8 bits and stop at 255 instead of wrapping. A page hit 300 times outranks a page hit 100 times when a victim is chosen.
- R4: A miss with all frames full reports evict_valid=1 and the evicted page number. The new page is placed in the frame of the resident page with the lowest use count.
- R5: When several resident pages share the lowest use count, the one that was loaded earliest is evicted.
- R6: A page loaded on a miss starts with a use count of one, even if it was resident earlier with a higher count.
- R7: A result appears exactly one cycle after each reference with out_valid=1. out_valid is 0 in cycles that follow no reference, and in the cycle after reset.
- R8: For the reference string 1,2,3,4,1,2,5,1,2,3,4,5 starting from empty frames, exactly eight misses are reported.
- R9: Earliest-arrival tie-breaking stays correct after the 8-bit arrival counter has wrapped many times during long runs of misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; empties all frames |
| ref_valid | input | 1 | A page reference is present this cycle |
| ref_page | input | 8 | Referenced page number |
| out_valid | output | 1 | A result for the previous cycle's reference is present |
| out_hit | output | 1 | 1 if the referenced page was resident |
| out_frame | output | 2 | Frame that served the hit or received the loaded page |
| out_evict_valid | output | 1 | A resident page was evicted for this miss |
| out_evict_page | output | 8 | Page number that was evicted (0 when none) |

## Verification
Wrong state inside this block rarely shows up at once. A corrupted or wrapping use count, or a misordered arrival stamp, stays hidden until the next miss with all frames full, and then appears as the wrong evicted page and frame. Every miss is therefore compared against an independent frequency-and-age model, on deliberately built count ties, saturated counts and stamp wrap. A wrong match or fill decision shows up on the very next result as a wrong hit flag or frame index.

// File: rtl/lfu_pkg.sv
package lfu_pkg;

  // Classification of one reference cycle
  typedef enum logic [1:0] {
    REF_IDLE  = 2'd0,
    REF_HIT   = 2'd1,
    REF_FILL  = 2'd2,
    REF_EVICT = 2'd3
  } ref_kind_e;

  function automatic ref_kind_e classify(input logic valid, input logic hit,
                                         input logic any_empty);
    if (!valid)         return REF_IDLE;
    else if (hit)       return REF_HIT;
    else if (any_empty) return REF_FILL;
    else                return REF_EVICT;
  endfunction

endpackage

// File: rtl/lfu_stamp_counter.sv
module lfu_stamp_counter #(
  parameter int STAMP_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               step_en,
  output logic [STAMP_W-1:0] now_o
);

  logic [STAMP_W-1:0] now_q, now_d;

  always_comb begin
    now_d = now_q + STAMP_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      now_q <= '0;
    end else if (step_en) begin
      now_q <= now_d;
    end
  end

  assign now_o = now_q;

endmodule

// File: rtl/lfu_frame_table.sv
module lfu_frame_table #(
  parameter int NUM_FRAMES = 4,
  parameter int PAGE_W     = 8,
  parameter int CNT_W      = 8,
  parameter int STAMP_W    = 8,
  parameter int FRAME_W    = 2
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                wr_en,
  input  logic [FRAME_W-1:0]                  wr_idx,
  input  logic [PAGE_W-1:0]                   wr_page,
  input  logic [STAMP_W-1:0]                  wr_stamp,
  input  logic                                inc_en,
  input  logic [FRAME_W-1:0]                  inc_idx,
  output logic [NUM_FRAMES-1:0]               valid_o,
  output logic [NUM_FRAMES-1:0][PAGE_W-1:0]   page_o,
  output logic [NUM_FRAMES-1:0][CNT_W-1:0]    cnt_o,
  output logic [NUM_FRAMES-1:0][STAMP_W-1:0]  stamp_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [NUM_FRAMES-1:0]              valid_q, valid_d;
  logic [NUM_FRAMES-1:0][PAGE_W-1:0]  page_q, page_d;
  logic [NUM_FRAMES-1:0][CNT_W-1:0]   cnt_q, cnt_d;
  logic [NUM_FRAMES-1:0][STAMP_W-1:0] stamp_q, stamp_d;

  genvar g;
  generate
    for (g = 0; g < NUM_FRAMES; g++) begin : g_frame
      logic load_here, bump_here;
      assign load_here = wr_en && (wr_idx == FRAME_W'(g));
      assign bump_here = inc_en && (inc_idx == FRAME_W'(g));

      always_comb begin
        valid_d[g] = valid_q[g];
        page_d[g]  = page_q[g];
        cnt_d[g]   = cnt_q[g];
        stamp_d[g] = stamp_q[g];
        if (load_here) begin
          valid_d[g] = 1'b1;
          page_d[g]  = wr_page;
          cnt_d[g]   = CNT_W'(1);
          stamp_d[g] = wr_stamp;
        end else if (bump_here && (cnt_q[g] != CNT_MAX)) begin
          cnt_d[g] = cnt_q[g] + CNT_W'(1);
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          valid_q[g] <= 1'b0;
          page_q[g]  <= '0;
          cnt_q[g]   <= '0;
          stamp_q[g] <= '0;
        end else if (load_here || bump_here) begin
          valid_q[g] <= valid_d[g];
          page_q[g]  <= page_d[g];
          cnt_q[g]   <= cnt_d[g];
          stamp_q[g] <= stamp_d[g];
        end
      end

      // R3: a saturated count stays at its ceiling on further hits
      p_cnt_saturates_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_q[g] && bump_here && !load_here && cnt_q[g] == CNT_MAX)
          |=> (cnt_q[g] == CNT_MAX));

      // R6: an occupied frame never shows a zero count
      p_cnt_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q[g] |-> (cnt_q[g] != '0));

      if (g > 0) begin : g_order
        // R1: frames are occupied strictly in index order
        p_fill_order_r1: assert property (@(posedge clk) disable iff (!rst_n)
          valid_q[g] |-> valid_q[g-1]);
      end
    end
  endgenerate

  // R6: a load always leaves the loaded frame at count one
  p_load_count_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (cnt_q[$past(wr_idx)] == CNT_W'(1)));

  assign valid_o = valid_q;
  assign page_o  = page_q;
  assign cnt_o   = cnt_q;
  assign stamp_o = stamp_q;

endmodule

// File: rtl/lfu_lookup.sv
module lfu_lookup #(
  parameter int NUM_FRAMES = 4,
  parameter int PAGE_W     = 8,
  parameter int FRAME_W    = 2
) (
  input  logic [PAGE_W-1:0]                 ref_page,
  input  logic [NUM_FRAMES-1:0]             valid_i,
  input  logic [NUM_FRAMES-1:0][PAGE_W-1:0] page_i,
  output logic                              hit_o,
  output logic [FRAME_W-1:0]                hit_idx_o,
  output logic                              any_empty_o,
  output logic [FRAME_W-1:0]                empty_idx_o
);

  logic [NUM_FRAMES-1:0] match;

  genvar g;
  generate
    for (g = 0; g < NUM_FRAMES; g++) begin : g_cmp
      assign match[g] = valid_i[g] && (page_i[g] == ref_page);
    end
  endgenerate

  always_comb begin
    hit_o     = 1'b0;
    hit_idx_o = '0;
    for (int i = 0; i < NUM_FRAMES; i++) begin
      if (match[i] && !hit_o) begin
        hit_o     = 1'b1;
        hit_idx_o = FRAME_W'(i);
      end
    end
  end

  always_comb begin
    any_empty_o = 1'b0;
    empty_idx_o = '0;
    for (int i = 0; i < NUM_FRAMES; i++) begin
      if (!valid_i[i] && !any_empty_o) begin
        any_empty_o = 1'b1;
        empty_idx_o = FRAME_W'(i);
      end
    end
  end

endmodule

// File: rtl/lfu_victim_select.sv
module lfu_victim_select #(
  parameter int NUM_FRAMES = 4,
  parameter int CNT_W      = 8,
  parameter int STAMP_W    = 8,
  parameter int FRAME_W    = 2
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               check_en,
  input  logic [NUM_FRAMES-1:0][CNT_W-1:0]   cnt_i,
  input  logic [NUM_FRAMES-1:0][STAMP_W-1:0] stamp_i,
  input  logic [STAMP_W-1:0]                 now_i,
  output logic [FRAME_W-1:0]                 victim_o
);

  logic [NUM_FRAMES-1:0][STAMP_W-1:0] age;
  logic [CNT_W-1:0]                   best_cnt;
  logic [STAMP_W-1:0]                 best_age;

  genvar g;
  generate
    for (g = 0; g < NUM_FRAMES; g++) begin : g_age
      // Distance back from the current stamp; stays ordered across wrap
      assign age[g] = now_i - stamp_i[g];
    end
  endgenerate

  always_comb begin
    victim_o = '0;
    best_cnt = cnt_i[0];
    best_age = age[0];
    for (int i = 1; i < NUM_FRAMES; i++) begin
      if ((cnt_i[i] < best_cnt) ||
          ((cnt_i[i] == best_cnt) && (age[i] > best_age))) begin
        victim_o = FRAME_W'(i);
        best_cnt = cnt_i[i];
        best_age = age[i];
      end
    end
  end

  generate
    for (g = 0; g < NUM_FRAMES; g++) begin : g_chk
      // R4: no frame holds a smaller count than the chosen victim
      p_victim_minimal_r4: assert property (@(posedge clk) disable iff (!rst_n)
        check_en |-> (cnt_i[victim_o] <= cnt_i[g]));
    end
  endgenerate

endmodule

// File: rtl/lfu_frame_replacer.sv
module lfu_frame_replacer #(
  parameter int NUM_FRAMES = 4,
  parameter int PAGE_W     = 8,
  parameter int CNT_W      = 8,
  parameter int STAMP_W    = 8,
  parameter int FRAME_W    = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ref_valid,
  input  logic [PAGE_W-1:0]  ref_page,
  output logic               out_valid,
  output logic               out_hit,
  output logic [FRAME_W-1:0] out_frame,
  output logic               out_evict_valid,
  output logic [PAGE_W-1:0]  out_evict_page
);

  import lfu_pkg::*;

  logic [NUM_FRAMES-1:0]              valid_w;
  logic [NUM_FRAMES-1:0][PAGE_W-1:0]  page_w;
  logic [NUM_FRAMES-1:0][CNT_W-1:0]   cnt_w;
  logic [NUM_FRAMES-1:0][STAMP_W-1:0] stamp_w;
  logic [STAMP_W-1:0]                 now_w;

  logic               hit_w, any_empty_w;
  logic [FRAME_W-1:0] hit_idx_w, empty_idx_w, victim_w;
  ref_kind_e          kind;

  logic               load_en;
  logic [FRAME_W-1:0] load_idx;
  logic               bump_en;

  logic               res_hit_d, res_evict_d;
  logic [FRAME_W-1:0] res_frame_d;
  logic [PAGE_W-1:0]  res_page_d;

  logic               out_valid_q, out_hit_q, out_evict_q;
  logic [FRAME_W-1:0] out_frame_q;
  logic [PAGE_W-1:0]  out_page_q;

  lfu_stamp_counter #(.STAMP_W(STAMP_W)) u_stamp (
    .clk     (clk),
    .rst_n   (rst_n),
    .step_en (load_en),
    .now_o   (now_w)
  );

  lfu_frame_table #(
    .NUM_FRAMES (NUM_FRAMES),
    .PAGE_W     (PAGE_W),
    .CNT_W      (CNT_W),
    .STAMP_W    (STAMP_W),
    .FRAME_W    (FRAME_W)
  ) u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (load_en),
    .wr_idx   (load_idx),
    .wr_page  (ref_page),
    .wr_stamp (now_w),
    .inc_en   (bump_en),
    .inc_idx  (hit_idx_w),
    .valid_o  (valid_w),
    .page_o   (page_w),
    .cnt_o    (cnt_w),
    .stamp_o  (stamp_w)
  );

  lfu_lookup #(
    .NUM_FRAMES (NUM_FRAMES),
    .PAGE_W     (PAGE_W),
    .FRAME_W    (FRAME_W)
  ) u_lookup (
    .ref_page    (ref_page),
    .valid_i     (valid_w),
    .page_i      (page_w),
    .hit_o       (hit_w),
    .hit_idx_o   (hit_idx_w),
    .any_empty_o (any_empty_w),
    .empty_idx_o (empty_idx_w)
  );

  lfu_victim_select #(
    .NUM_FRAMES (NUM_FRAMES),
    .CNT_W      (CNT_W),
    .STAMP_W    (STAMP_W),
    .FRAME_W    (FRAME_W)
  ) u_victim (
    .clk      (clk),
    .rst_n    (rst_n),
    .check_en (kind == REF_EVICT),
    .cnt_i    (cnt_w),
    .stamp_i  (stamp_w),
    .now_i    (now_w),
    .victim_o (victim_w)
  );

  // Decision for the current reference
  always_comb begin
    kind        = classify(ref_valid, hit_w, any_empty_w);
    load_en     = 1'b0;
    load_idx    = '0;
    bump_en     = 1'b0;
    res_hit_d   = 1'b0;
    res_evict_d = 1'b0;
    res_frame_d = '0;
    res_page_d  = '0;
    unique case (kind)
      REF_HIT: begin
        bump_en     = 1'b1;
        res_hit_d   = 1'b1;
        res_frame_d = hit_idx_w;
      end
      REF_FILL: begin
        load_en     = 1'b1;
        load_idx    = empty_idx_w;
        res_frame_d = empty_idx_w;
      end
      REF_EVICT: begin
        load_en     = 1'b1;
        load_idx    = victim_w;
        res_frame_d = victim_w;
        res_evict_d = 1'b1;
        res_page_d  = page_w[victim_w];
      end
      default: ;
    endcase
  end

  // Result registers, loaded only when a reference is present
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid_q <= 1'b0;
    end else begin
      out_valid_q <= ref_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_hit_q   <= 1'b0;
      out_evict_q <= 1'b0;
      out_frame_q <= '0;
      out_page_q  <= '0;
    end else if (ref_valid) begin
      out_hit_q   <= res_hit_d;
      out_evict_q <= res_evict_d;
      out_frame_q <= res_frame_d;
      out_page_q  <= res_page_d;
    end
  end

  assign out_valid       = out_valid_q;
  assign out_hit         = out_hit_q;
  assign out_frame       = out_frame_q;
  assign out_evict_valid = out_evict_q;
  assign out_evict_page  = out_page_q;

  // R2: a hit never reports an eviction
  p_hit_no_evict_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_hit) |-> !out_evict_valid);

  // R7: a result follows each reference by one cycle
  p_result_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ref_valid |=> out_valid);

  // R7: no result after an idle cycle
  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_valid |=> !out_valid);

  // R4: an eviction is only chosen when every frame is occupied
  p_evict_when_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_valid && !hit_w && !any_empty_w) |-> (&valid_w));

  // R4: the evicted page really left its frame for the new one
  p_evict_replaced_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == REF_EVICT) |=> (page_w[$past(victim_w)] == $past(ref_page)));

endmodule

// File: tb/tb_lfu_frame_replacer.sv
module tb_lfu_frame_replacer;

  localparam int NF = 4;

  logic       clk;
  logic       rst_n;
  logic       ref_valid;
  logic [7:0] ref_page;
  logic       out_valid;
  logic       out_hit;
  logic [1:0] out_frame;
  logic       out_evict_valid;
  logic [7:0] out_evict_page;

  lfu_frame_replacer dut (
    .clk             (clk),
    .rst_n           (rst_n),
    .ref_valid       (ref_valid),
    .ref_page        (ref_page),
    .out_valid       (out_valid),
    .out_hit         (out_hit),
    .out_frame       (out_frame),
    .out_evict_valid (out_evict_valid),
    .out_evict_page  (out_evict_page)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  typedef struct packed {
    logic       hit;
    logic [1:0] frame;
    logic       ev;
    logic [7:0] evp;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];

  int checks = 0;
  int errors = 0;
  int r8_misses = 0;
  bit done = 0;

  // Independent model of the replacement rules
  int m_valid[NF];
  int m_page[NF];
  int m_cnt[NF];
  int m_stamp[NF];
  int m_now;

  task automatic model_reset();
    for (int i = 0; i < NF; i++) begin
      m_valid[i] = 0; m_page[i] = 0; m_cnt[i] = 0; m_stamp[i] = 0;
    end
    m_now = 0;
  endtask

  function automatic exp_t model_ref(input int p);
    exp_t e;
    int f;
    e = '0;
    f = -1;
    for (int i = 0; i < NF; i++)
      if (m_valid[i] != 0 && m_page[i] == p) f = i;
    if (f >= 0) begin
      e.hit = 1'b1;
      e.frame = 2'(f);
      if (m_cnt[f] < 255) m_cnt[f]++;
      return e;
    end
    for (int i = NF - 1; i >= 0; i--)
      if (m_valid[i] == 0) f = i;
    if (f < 0) begin
      f = 0;
      for (int i = 1; i < NF; i++)
        if (m_cnt[i] < m_cnt[f] || (m_cnt[i] == m_cnt[f] && m_stamp[i] < m_stamp[f]))
          f = i;
      e.ev = 1'b1;
      e.evp = 8'(m_page[f]);
    end
    e.frame = 2'(f);
    m_valid[f] = 1; m_page[f] = p; m_cnt[f] = 1; m_stamp[f] = m_now;
    m_now++;
    return e;
  endfunction

  task automatic drive(input int p, input string tag);
    @(negedge clk);
    ref_valid = 1'b1;
    ref_page  = 8'(p);
    exp_q.push_back(model_ref(p));
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      ref_valid = 1'b0;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    ref_valid = 1'b0;
    rst_n = 1'b0;
    model_reset();
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Monitor: compare each result with the oldest pending expectation
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      exp_t  e;
      string t;
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R7: unexpected result, out_valid=%0d expected 0", out_valid);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (t == "R8" && !out_hit) r8_misses++;
        if (out_hit !== e.hit || out_frame !== e.frame || out_evict_valid !== e.ev ||
            (e.ev && out_evict_page !== e.evp)) begin
          errors++;
          $display("FAIL %s: hit=%0d frame=%0d ev=%0d evp=%0d expected hit=%0d frame=%0d ev=%0d evp=%0d",
                   t, out_hit, out_frame, out_evict_valid, out_evict_page,
                   e.hit, e.frame, e.ev, e.evp);
        end
      end
    end
  end

  task automatic check_idle(input string tag);
    @(negedge clk);
    #1;
    checks++;
    if (out_valid !== 1'b0) begin
      errors++;
      $display("FAIL %s: out_valid=%0d expected 0", tag, out_valid);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #400000;
    errors++;
    checks++;
    $display("FAIL watchdog: run did not complete, finished=0 expected 1");
    finish_run();
  end

  initial begin
    ref_valid = 1'b0;
    ref_page  = '0;
    rst_n     = 1'b0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R7: no result right after reset
    check_idle("R7");

    // R1 and R8: in-order fill, then the classic string with eight misses
    begin
      int s[12] = '{1, 2, 3, 4, 1, 2, 5, 1, 2, 3, 4, 5};
      for (int i = 0; i < 12; i++) drive(s[i], (i < 4) ? "R1" : "R8");
      idle(2);
    end
    begin
      // the first four are also misses of the string
      checks++;
      if (r8_misses + 4 != 8) begin
        errors++;
        $display("FAIL R8: misses=%0d expected 8", r8_misses + 4);
      end
    end

    // R2, R4, R5, R6, R7 with idle gaps
    do_reset();
    drive(20, "R1"); drive(21, "R1"); drive(22, "R1"); drive(23, "R1");
    idle(1);
    check_idle("R7");
    drive(20, "R2"); idle(2); drive(21, "R2"); drive(20, "R2"); drive(21, "R2");
    drive(24, "R4");   // counts 3,3,1,1: oldest of 22,23 goes
    drive(25, "R5");   // tie 23 vs 24
    drive(22, "R6");   // reloaded at count one
    drive(26, "R6");   // tie 25 vs 22, 25 older
    drive(27, "R5");
    drive(20, "R2");
    idle(2);

    // R3: saturated count beats a count of 101
    do_reset();
    drive(30, "R1"); drive(31, "R1"); drive(32, "R1"); drive(33, "R1");
    for (int k = 0; k < 300; k++) drive(30, "R3");
    for (int k = 0; k < 100; k++) begin
      drive(31, "R3"); drive(32, "R3"); drive(33, "R3");
    end
    drive(34, "R3");
    drive(35, "R3");
    idle(2);

    // R9: long miss run wraps the arrival counter
    do_reset();
    drive(40, "R9"); drive(41, "R9");
    drive(40, "R9"); drive(41, "R9");
    for (int r = 0; r < 2; r++)
      for (int p = 50; p < 251; p++) drive(p, "R9");
    drive(40, "R9"); drive(41, "R9");
    drive(7, "R9");
    idle(3);

    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R7: pending results=%0d expected 0", exp_q.size());
    end
    finish_run();
  end

endmodule